// File: doc/BRIEF.md
# External Interrupt Pending-Flag Controller

This block sits between a small processor core and up to eight external pins that have already been synchronised to the core clock. Each pin has a 2-bit trigger setting. An edge-triggered pin latches a pending flag when its selected transition occurs, and it does so whether or not interrupts are currently enabled. A pin in level mode does not latch anything: its request follows the pin level for as long as the pin is held low.

A pending source raises a request to the core when two further conditions hold: its bit in the mask register is one, and the global enable is one. The block always presents the lowest-numbered requesting pin, together with its index. When the core takes that vector, the block clears the pin's flag and also clears the global enable. The enable comes back on a return-from-interrupt pulse. Software can also set or clear the enable directly. Software clears flags by writing ones through a write-one-to-clear port.

Because each source keeps a single flag, any number of edges that arrive during a service routine leave only one pending request. Requests that are waiting when the routine returns are then served one per return, in priority order.

Top module: `irq_front`

## Requirements
- R1: After reset, all flags, all mask bits and the global enable are zero, and irq_o is low.
- R2: Trigger field bits [2i+1:2i] of mode_i select pin i's trigger: 0 is rising edge, 1 is falling edge, 2 is any change, 3 is low level. A selected edge sets flag i one cycle later, even while the global enable is zero. The first cycle after reset detects no edge.
- R3: irq_o is high exactly when the global enable is one and some pin i has mask bit i set together with either flag i set or an active low-level request.
- R4: When several pins request at once, irq_idx_o names the lowest-numbered one.
- R5: take_i while irq_o is high clears the flag of the pin named by irq_idx_o and clears the global enable on the next edge. take_i while irq_o is low has no effect.
- R6: Precedence for the global enable is: an accepted take clears it; otherwise gie_clr_i clears it; otherwise gie_set_i or reti_i sets it. mask_we_i loads mask_wdata_i into the mask.
- R7: With flag_clr_we_i high, each one bit in flag_clr_data_i clears that flag. Zero bits leave their flags unchanged.
- R8: A pin in low-level mode always reads zero in flags_o. It requests while its pin is low and stops requesting when the pin goes high.
- R9: A source holds at most one pending request. Extra edges that arrive while its flag is set leave a single flag, which a single take removes.
- R10: A selected edge that arrives in the same cycle as a take or a software clear of that pin leaves the flag set.
- R11: Requests that become pending while the enable is off are presented one at a time after each return, lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_SRC | Synchronised external pins |
| mode_i | input | 2*N_SRC | Per-pin trigger select, 2 bits per pin |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | N_SRC | Mask write data |
| flag_clr_we_i | input | 1 | Flag clear strobe |
| flag_clr_data_i | input | N_SRC | Write-one-to-clear data for the flags |
| gie_set_i | input | 1 | Software sets the global enable |
| gie_clr_i | input | 1 | Software clears the global enable |
| take_i | input | 1 | Core takes the presented vector |
| reti_i | input | 1 | Core returns from an interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| irq_idx_o | output | $clog2(N_SRC) | Index of the presented source |
| flags_o | output | N_SRC | Pending flags |
| mask_o | output | N_SRC | Mask register |
| gie_o | output | 1 | Global enable |

## Verification
Flags, mask and enable are registered, so the effect of a pin transition, write, take or return shows on flags_o, mask_o and gie_o just after the next rising edge. irq_o and irq_idx_o are combinational from those registers and from the level-mode pins, so a new request appears in that same cycle. The bench applies inputs at the falling edge and samples 1 ns after the rising edge. Its reference model advances by exactly one state update per edge, and it compares every output against that model at this sampling point. That covers both directed corner sequences and seeded random traffic.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_ANY  = 2'd2,
    TRIG_LOW  = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/irq_trig_det.sv
module irq_trig_det
  import irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   pin_i,
  input  logic [2*N_SRC-1:0] mode_i,
  output logic [N_SRC-1:0]   hit_o,
  output logic [N_SRC-1:0]   lvl_mode_o,
  output logic [N_SRC-1:0]   lvl_req_o
);
  logic [N_SRC-1:0] prev_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      vld_q  <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_pin
    trig_mode_e m;
    assign m = trig_mode_e'(mode_i[2*g +: 2]);
    always_comb begin
      unique case (m)
        TRIG_RISE: hit_o[g] = vld_q & pin_i[g] & ~prev_q[g];
        TRIG_FALL: hit_o[g] = vld_q & ~pin_i[g] & prev_q[g];
        TRIG_ANY:  hit_o[g] = vld_q & (pin_i[g] ^ prev_q[g]);
        default:   hit_o[g] = 1'b0;
      endcase
    end
    assign lvl_mode_o[g] = (m == TRIG_LOW);
    assign lvl_req_o[g]  = lvl_mode_o[g] & ~pin_i[g];
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hit_i,
  input  logic [N_SRC-1:0] lvl_mode_i,
  input  logic [N_SRC-1:0] take_oh_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  output logic [N_SRC-1:0] flags_o
);
  logic [N_SRC-1:0] flags_q, flags_d;

  // a fresh edge beats any clear in the same cycle
  assign flags_d = ((flags_q & ~take_oh_i & ~sw_clr_i) | hit_i) & ~lvl_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_SRC-1:0] onehot_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    onehot_o = '0;
    if (valid_o) onehot_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/irq_front.sv
module irq_front #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   pin_i,
  input  logic [2*N_SRC-1:0] mode_i,
  input  logic               mask_we_i,
  input  logic [N_SRC-1:0]   mask_wdata_i,
  input  logic               flag_clr_we_i,
  input  logic [N_SRC-1:0]   flag_clr_data_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               take_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   irq_idx_o,
  output logic [N_SRC-1:0]   flags_o,
  output logic [N_SRC-1:0]   mask_o,
  output logic               gie_o
);
  logic [N_SRC-1:0] hit, lvl_mode, lvl_req, flags, pend, pick_oh, take_oh, sw_clr;
  logic [N_SRC-1:0] mask_q;
  logic             gie_q, pick_vld, take_ok;
  logic [IDX_W-1:0] pick_idx;

  irq_trig_det #(.N_SRC(N_SRC)) u_det (
    .clk_i, .rst_ni, .pin_i, .mode_i,
    .hit_o(hit), .lvl_mode_o(lvl_mode), .lvl_req_o(lvl_req)
  );

  assign sw_clr  = flag_clr_we_i ? flag_clr_data_i : '0;
  assign take_ok = take_i & irq_o;
  assign take_oh = take_ok ? pick_oh : '0;

  irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk_i, .rst_ni, .hit_i(hit), .lvl_mode_i(lvl_mode),
    .take_oh_i(take_oh), .sw_clr_i(sw_clr), .flags_o(flags)
  );

  assign pend = (flags | lvl_req) & mask_q;

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .req_i(pend), .valid_o(pick_vld), .idx_o(pick_idx), .onehot_o(pick_oh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (take_ok)                 gie_q <= 1'b0;
      else if (gie_clr_i)          gie_q <= 1'b0;
      else if (gie_set_i | reti_i) gie_q <= 1'b1;
    end
  end

  assign irq_o     = gie_q & pick_vld;
  assign irq_idx_o = pick_idx;
  assign flags_o   = flags;
  assign mask_o    = mask_q;
  assign gie_o     = gie_q;
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2*N_SRC-1:0] mode_i,
  input logic               gie_clr_i,
  input logic               take_i,
  input logic               reti_i,
  input logic               irq_o,
  input logic [IDX_W-1:0]   irq_idx_o,
  input logic [N_SRC-1:0]   flags_o,
  input logic [N_SRC-1:0]   mask_o,
  input logic               gie_o
);
  logic [N_SRC-1:0] below;
  always_comb begin
    below = '0;
    for (int i = 0; i < N_SRC; i++) below[i] = (i < int'(irq_idx_o));
  end

  AST_TAKE_DROPS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && irq_o) |=> !gie_o); // R5

  AST_RETI_RESTORES_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !(take_i && irq_o) && !gie_clr_i) |=> gie_o); // R6

  AST_REQ_NEEDS_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_o && mask_o[irq_idx_o])); // R3

  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flags_o & mask_o & below) == '0)); // R4

  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    AST_LEVEL_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(mode_i[2*g +: 2]) == 2'd3) |-> !flags_o[g]); // R8
  end
endmodule

bind irq_front irq_front_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .gie_clr_i(gie_clr_i),
  .take_i(take_i), .reti_i(reti_i), .irq_o(irq_o), .irq_idx_o(irq_idx_o),
  .flags_o(flags_o), .mask_o(mask_o), .gie_o(gie_o)
);

// File: tb/tb_irq_front.sv
module tb_irq_front;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] pin = '0, mask_wdata = '0, clr_data = '0;
  logic [2*N-1:0] mode = '0;
  logic mask_we = 0, clr_we = 0, gie_set = 0, gie_clr = 0, take = 0, reti = 0;
  logic irq; logic [IW-1:0] idx; logic [N-1:0] flags, mask; logic gie;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [N-1:0] m_flags = '0, m_mask = '0, m_prev = '0;
  logic m_gie = 0, m_vld = 0;

  always #10 clk = ~clk;

  irq_front #(.N_SRC(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .mode_i(mode),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .flag_clr_we_i(clr_we), .flag_clr_data_i(clr_data),
    .gie_set_i(gie_set), .gie_clr_i(gie_clr), .take_i(take), .reti_i(reti),
    .irq_o(irq), .irq_idx_o(idx), .flags_o(flags), .mask_o(mask), .gie_o(gie)
  );

  function automatic logic [N-1:0] lvl_req();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (mode[2*i +: 2] == 2'd3) && !pin[i];
    return r;
  endfunction

  function automatic logic [N-1:0] pend();
    return (m_flags | lvl_req()) & m_mask;
  endfunction

  function automatic logic exp_irq();
    return m_gie && (pend() != '0);
  endfunction

  function automatic logic [IW-1:0] exp_idx();
    logic [N-1:0] p = pend();
    for (int i = 0; i < N; i++) if (p[i]) return IW'(i);
    return '0;
  endfunction

  task automatic model_edge();
    logic tk = take && exp_irq();
    logic [IW-1:0] ti = exp_idx();
    logic [N-1:0] nf;
    for (int i = 0; i < N; i++) begin
      logic [1:0] md = mode[2*i +: 2];
      logic hit;
      hit = m_vld && ((md == 0 && pin[i] && !m_prev[i]) ||
                      (md == 1 && !pin[i] && m_prev[i]) ||
                      (md == 2 && pin[i] != m_prev[i]));
      nf[i] = m_flags[i];
      if (tk && ti == IW'(i)) nf[i] = 1'b0;
      if (clr_we && clr_data[i]) nf[i] = 1'b0;
      if (hit) nf[i] = 1'b1;
      if (md == 3) nf[i] = 1'b0;
    end
    m_flags = nf;
    m_prev = pin; m_vld = 1'b1;
    if (mask_we) m_mask = mask_wdata;
    if (tk) m_gie = 1'b0;
    else if (gie_clr) m_gie = 1'b0;
    else if (gie_set || reti) m_gie = 1'b1;
  endtask

  task automatic cmp(string tag);
    checks++;
    if (flags !== m_flags || mask !== m_mask || gie !== m_gie || irq !== exp_irq() ||
        (exp_irq() && idx !== exp_idx())) begin
      errors++;
      $display("FAIL %s: flags=%h mask=%h gie=%b irq=%b idx=%0d exp flags=%h mask=%h gie=%b irq=%b idx=%0d",
               tag, flags, mask, gie, irq, idx, m_flags, m_mask, m_gie, exp_irq(), exp_idx());
    end
  endtask

  // one clock: inputs already set at negedge
  task automatic step(string tag);
    model_edge();
    @(posedge clk); #1;
    cmp(tag);
    @(negedge clk);
    mask_we = 0; clr_we = 0; gie_set = 0; gie_clr = 0; take = 0; reti = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    #1; cmp("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    step("R1");

    // R2: edges latch while gie off
    mask_we = 1; mask_wdata = '1; step("R6");
    pin[0] = 1; step("R2");
    mode[3:2] = 2'd1; pin[1] = 1; step("R2");
    pin[1] = 0; step("R2");
    mode[5:4] = 2'd2; pin[2] = 1; step("R2");
    // R3/R4: enable, lowest index presented
    gie_set = 1; step("R3");
    step("R4");
    // R5: take pin0
    take = 1; step("R5");
    take = 1; step("R5"); // ignored, irq low
    // R9: extra edges on pending pin2 collapse
    pin[2] = 0; step("R9");
    pin[2] = 1; step("R9");
    // R11: one per return
    reti = 1; step("R11");
    take = 1; step("R11");
    reti = 1; step("R11");
    take = 1; step("R9");
    reti = 1; step("R11");
    // R6: precedence of clear over set
    gie_set = 1; gie_clr = 1; step("R6");
    // R7: W1C with zeros elsewhere
    pin[0] = 0; step("R7");
    pin[0] = 1; pin[1] = 1; step("R7");
    pin[1] = 0; step("R7");
    clr_we = 1; clr_data = 8'h01; step("R7");
    clr_we = 1; clr_data = 8'h00; step("R7");
    // R10: edge with sw clear in same cycle
    mode[1:0] = 2'd2; pin[0] = 0; clr_we = 1; clr_data = 8'h01; step("R10");
    clr_we = 1; clr_data = 8'h02; step("R7");
    // R10: edge during take of same pin
    gie_set = 1; step("R3");
    pin[0] = 1; take = 1; step("R10");
    // R8: low level
    mode[7:6] = 2'd3; pin[3] = 0; gie_set = 1; step("R8");
    clr_we = 1; clr_data = 8'h01; step("R8");
    pin[3] = 1; step("R8");
    pin[3] = 0; step("R8");
    mode[7:6] = 2'd0; step("R8");

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 31) == 0) mode = 16'($urandom);
      pin = pin ^ (N'($urandom) & N'($urandom) & N'($urandom));
      mask_we = ($urandom_range(0, 15) == 0); mask_wdata = N'($urandom);
      clr_we = ($urandom_range(0, 7) == 0); clr_data = N'($urandom);
      gie_set = ($urandom_range(0, 9) == 0);
      gie_clr = ($urandom_range(0, 19) == 0);
      take = ($urandom_range(0, 2) == 0);
      reti = ($urandom_range(0, 5) == 0);
      step("R3");
    end
    finish_run();
  end
endmodule